// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock Core

This block is the timekeeping core of a real-time clock. A 32768 Hz tick enable feeds a sub-second down-counter that produces one step per second. The step advances a packed-BCD calendar covering seconds, minutes, hours, day of month, month, two-digit year (2000 to 2099) and a weekday. Month lengths and leap Februaries are handled in hardware.

Software reaches the core through a simple byte-wide register port. It stops the clock, writes the seven time fields, then restarts it. To read the time, it raises a snapshot bit that freezes a coherent copy of the live time into shadow registers. A signed correction can trim the length of one second per hour to cancel crystal drift. A six-field alarm raises a sticky flag and an interrupt when the live time matches it, provided the alarm interrupt is enabled.

Register map (byte addresses): 0 to 6 time (second, minute, hour, day, month, year, weekday); 8 to 13 alarm (second, minute, hour, day, month, year); 14 control; 15 alarm interrupt; 16 and 17 correction low and high byte; 18 status.

Top module: `rtc_calendar_core`

## Requirements
- R1: A write to address 0 to 6 loads the live time field in the order second, minute, hour, day, month (1 to 12), year (00 to 99), weekday (0 to 6), all packed BCD. A read of address 0 to 6 returns the shadow copy, never the live counter. After reset the time is 2000-01-01 00:00:00 with weekday 0, and all shadows read 0.
- R2: A write to address 14 with bit 1 set copies all seven live fields into the shadows, but only if bit 1 was 0 before. Writing bit 1 as 1 again while it is already 1 leaves the shadows unchanged.
- R3: Control bit 0 (address 14) enables counting. While it is 0, the calendar does not advance and the sub-second counter holds its full-second reload value.
- R4: The running flag (`running_o`, address 18 bit 0) sets on the first tick after counting is enabled. It clears on the clock after counting is disabled.
- R5: Without correction, one second elapses every TICKS_PER_SEC tick enables.
- R6: Seconds and minutes wrap from 59 to 00, and hours wrap from 23 to 00, each carrying into the next field.
- R7: The day wraps to 01 after day 28, 29, 30 or 31 according to the month. February has 29 days when the binary year is divisible by 4. The weekday advances with every day change and wraps from 6 to 0.
- R8: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R9: The correction is a signed 16-bit value (address 16 low byte, 17 high byte). When control bit 2 is set and a second elapses while second and minute are both 00, the second that follows lasts TICKS_PER_SEC minus the correction ticks, with a minimum of one tick. When bit 2 is 0, the correction has no effect.
- R10: Address 15 bit 0 enables the alarm interrupt. When the six live fields first equal the six alarm fields while the enable is set, the alarm flag (address 15 bit 1) sets and `alarm_irq_o` follows the flag.
- R11: The alarm flag stays set until software writes 1 to address 15 bit 1, which clears it. A new match in the same cycle wins over the clear. A match that persists after the clear does not set the flag again.
- R12: With the alarm enable at 0, a match does not set the flag and does not raise `alarm_irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle enable at 32768 Hz |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address for read and write |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from address |
| running_o | output | 1 | Counter running status |
| alarm_irq_o | output | 1 | Alarm interrupt, level |

## Verification
The assertions assume that software writes only legal packed-BCD values into the time fields: digits 0 to 9, ranges matching each field, and a weekday of 0 to 6. They also assume the day written fits the month written. Under these assumptions the weekday range check and the carry chain hold. The stimulus writes only valid calendar dates and changes the time only while counting is stopped. It keeps the tick enable to at most one pulse per clock. Every cycle, a behavioural reference model in the bench is compared against the read port, the running flag and the interrupt.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_TIME = 7;
  localparam int NUM_ALM  = 6;

  typedef logic [NUM_TIME-1:0][7:0] time_vec_t;
  typedef logic [NUM_ALM-1:0][7:0]  alm_vec_t;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;
  localparam int F_WDAY = 6;

  localparam logic [4:0] A_TIME_LAST = 5'd6;
  localparam logic [4:0] A_ALM0      = 5'd8;
  localparam logic [4:0] A_ALM_LAST  = 5'd13;
  localparam logic [4:0] A_CTRL      = 5'd14;
  localparam logic [4:0] A_IRQ       = 5'd15;
  localparam logic [4:0] A_COMP_LO   = 5'd16;
  localparam logic [4:0] A_COMP_HI   = 5'd17;
  localparam logic [4:0] A_STAT      = 5'd18;

  function automatic logic [7:0] bcd_inc(logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd2bin(logic [7:0] v);
    return ({3'b0, v[7:4]} * 7'd10) + {3'b0, v[3:0]};
  endfunction

  function automatic logic [7:0] last_day(logic [7:0] mon, logic [7:0] year);
    logic [6:0] yb;
    yb = bcd2bin(year);
    case (mon)
      8'h02:                      return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               tick_i,
  input  logic               apply_i,
  input  logic signed [15:0] comp_i,
  output logic               sec_pulse_o
);
  localparam int CNT_W = $clog2(TICKS_PER_SEC + 32768);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;
  int               rl;

  // shortened or stretched second, floored at one tick
  always_comb begin
    rl = TICKS_PER_SEC - 1 - int'(comp_i);
    if (rl < 0) rl = 0;
    reload = apply_i ? CNT_W'(rl) : FULL;
  end

  assign sec_pulse_o = run_i && tick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= FULL;
    else if (!run_i)      cnt_q <= FULL;
    else if (tick_i) begin
      if (cnt_q == '0)    cnt_q <= reload;
      else                cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_full_second_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_pulse_o && !apply_i) |=> (cnt_q == FULL));

  assert_floor_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_pulse_o && apply_i && (int'(comp_i) >= TICKS_PER_SEC)) |=> (cnt_q == '0));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       we_i,
  input  logic [4:0] waddr_i,
  input  logic [7:0] wdata_i,
  output time_vec_t  time_o
);
  time_vec_t cur_q, nxt;
  logic c_min, c_hour, c_day, c_mon, c_year;

  always_comb begin
    nxt    = cur_q;
    c_min  = step_i && (cur_q[F_SEC] == 8'h59);
    c_hour = c_min  && (cur_q[F_MIN] == 8'h59);
    c_day  = c_hour && (cur_q[F_HOUR] == 8'h23);
    c_mon  = c_day  && (cur_q[F_DAY] == last_day(cur_q[F_MON], cur_q[F_YEAR]));
    c_year = c_mon  && (cur_q[F_MON] == 8'h12);
    if (step_i) nxt[F_SEC]  = c_min  ? 8'h00 : bcd_inc(cur_q[F_SEC]);
    if (c_min)  nxt[F_MIN]  = c_hour ? 8'h00 : bcd_inc(cur_q[F_MIN]);
    if (c_hour) nxt[F_HOUR] = c_day  ? 8'h00 : bcd_inc(cur_q[F_HOUR]);
    if (c_day) begin
      nxt[F_DAY]  = c_mon ? 8'h01 : bcd_inc(cur_q[F_DAY]);
      nxt[F_WDAY] = (cur_q[F_WDAY] == 8'h06) ? 8'h00 : cur_q[F_WDAY] + 8'h01;
    end
    if (c_mon)  nxt[F_MON]  = c_year ? 8'h01 : bcd_inc(cur_q[F_MON]);
    if (c_year) nxt[F_YEAR] = (cur_q[F_YEAR] == 8'h99) ? 8'h00 : bcd_inc(cur_q[F_YEAR]);
    // software write overrides the step on the addressed field
    if (we_i && (waddr_i <= A_TIME_LAST)) nxt[waddr_i[2:0]] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q         <= '0;
      cur_q[F_DAY]  <= 8'h01;
      cur_q[F_MON]  <= 8'h01;
    end else begin
      cur_q <= nxt;
    end
  end

  assign time_o = cur_q;

  assert_wday_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q[F_WDAY] <= 8'h06));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [4:0] addr_i,
  input  logic [7:0] wdata_i,
  input  time_vec_t  live_i,
  output alm_vec_t   alm_o,
  output logic       ie_o,
  output logic       flag_o
);
  alm_vec_t           alm_q;
  logic               ie_q, flag_q, match_q;
  logic [NUM_ALM-1:0] eq;
  logic               match, set_w, clr_w;
  logic [4:0]         off;

  for (genvar g = 0; g < NUM_ALM; g++) begin : g_cmp
    assign eq[g] = (live_i[g] == alm_q[g]);
  end

  assign match = &eq;
  assign set_w = match && !match_q && ie_q;
  assign clr_w = we_i && (addr_i == A_IRQ) && wdata_i[1];
  assign off   = addr_i - A_ALM0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q   <= '0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      match_q <= match;
      if (we_i && (addr_i >= A_ALM0) && (addr_i <= A_ALM_LAST)) alm_q[off[2:0]] <= wdata_i;
      if (we_i && (addr_i == A_IRQ)) ie_q <= wdata_i[0];
      if (set_w)      flag_q <= 1'b1;
      else if (clr_w) flag_q <= 1'b0;
    end
  end

  assign alm_o  = alm_q;
  assign ie_o   = ie_q;
  assign flag_o = flag_q;

  assert_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_w) |=> flag_q);

  assert_gated_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ie_q && !flag_q) |=> !flag_q);
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       reg_we_i,
  input  logic [4:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       running_o,
  output logic       alarm_irq_o
);
  logic       run_q, snap_q, cen_q, running_q;
  logic [7:0] comp_lo_q, comp_hi_q;
  time_vec_t  live, shadow_q;
  alm_vec_t   alm;
  logic       ie, flag, step, apply, ctrl_we, snap_rise, time_we;
  logic [4:0] alm_off;

  assign ctrl_we   = reg_we_i && (reg_addr_i == A_CTRL);
  assign snap_rise = ctrl_we && reg_wdata_i[1] && !snap_q;
  assign time_we   = reg_we_i && (reg_addr_i <= A_TIME_LAST);
  assign apply     = cen_q && (live[F_SEC] == 8'h00) && (live[F_MIN] == 8'h00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      snap_q    <= 1'b0;
      cen_q     <= 1'b0;
      running_q <= 1'b0;
      comp_lo_q <= '0;
      comp_hi_q <= '0;
      shadow_q  <= '0;
    end else begin
      running_q <= run_q ? (running_q | tick_i) : 1'b0;
      if (snap_rise) shadow_q <= live;
      if (ctrl_we) begin
        run_q  <= reg_wdata_i[0];
        snap_q <= reg_wdata_i[1];
        cen_q  <= reg_wdata_i[2];
      end
      if (reg_we_i && (reg_addr_i == A_COMP_LO)) comp_lo_q <= reg_wdata_i;
      if (reg_we_i && (reg_addr_i == A_COMP_HI)) comp_hi_q <= reg_wdata_i;
    end
  end

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) i_prescaler (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_q),
    .tick_i      (tick_i),
    .apply_i     (apply),
    .comp_i      ($signed({comp_hi_q, comp_lo_q})),
    .sec_pulse_o (step)
  );

  rtc_calendar i_calendar (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .we_i    (reg_we_i),
    .waddr_i (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .time_o  (live)
  );

  rtc_alarm i_alarm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .live_i  (live),
    .alm_o   (alm),
    .ie_o    (ie),
    .flag_o  (flag)
  );

  assign alm_off = reg_addr_i - A_ALM0;

  always_comb begin
    reg_rdata_o = 8'h00;
    if (reg_addr_i <= A_TIME_LAST)                              reg_rdata_o = shadow_q[reg_addr_i[2:0]];
    else if ((reg_addr_i >= A_ALM0) && (reg_addr_i <= A_ALM_LAST)) reg_rdata_o = alm[alm_off[2:0]];
    else if (reg_addr_i == A_CTRL)    reg_rdata_o = {5'b0, cen_q, snap_q, run_q};
    else if (reg_addr_i == A_IRQ)     reg_rdata_o = {6'b0, flag, ie};
    else if (reg_addr_i == A_COMP_LO) reg_rdata_o = comp_lo_q;
    else if (reg_addr_i == A_COMP_HI) reg_rdata_o = comp_hi_q;
    else if (reg_addr_i == A_STAT)    reg_rdata_o = {7'b0, running_q};
  end

  assign running_o   = running_q;
  assign alarm_irq_o = flag;

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !time_we) |=> $stable(live));

  assert_running_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> !running_o);

  assert_shadow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_rise |=> $stable(shadow_q));
endmodule

// File: tb/test_rtc_calendar_core.sv
module test_rtc_calendar_core;
  localparam int TPS = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [4:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       running_o, alarm_irq_o;

  int    n_checks = 0, n_fail = 0, cyc = 0;
  bit    started = 0;
  string cur_tag = "R1";
  logic [7:0] ctrl_v = 8'h00;

  always #5 clk_i = ~clk_i;

  rtc_calendar_core #(.TICKS_PER_SEC(TPS)) i_rtc_calendar_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .reg_we_i(reg_we_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .running_o(running_o), .alarm_irq_o(alarm_irq_o)
  );

  // ---------------- reference model (binary time) ----------------
  int         m_t[7];
  logic [7:0] m_sh[7];
  logic [7:0] m_al[6];
  logic [7:0] m_clo, m_chi;
  bit         m_run, m_snap, m_cen, m_ie, m_flag, m_mq, m_running;
  int         m_cnt;
  bit         pulse, match, setf, clrf;
  int         rl;

  function automatic logic [7:0] tobcd(int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction
  function automatic int frombcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int mdays(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic advance();
    m_t[0]++;
    if (m_t[0] == 60) begin
      m_t[0] = 0; m_t[1]++;
      if (m_t[1] == 60) begin
        m_t[1] = 0; m_t[2]++;
        if (m_t[2] == 24) begin
          m_t[2] = 0; m_t[6] = (m_t[6] + 1) % 7; m_t[3]++;
          if (m_t[3] > mdays(m_t[4], m_t[5])) begin
            m_t[3] = 1; m_t[4]++;
            if (m_t[4] > 12) begin m_t[4] = 1; m_t[5] = (m_t[5] + 1) % 100; end
          end
        end
      end
    end
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_t = '{0, 0, 0, 1, 1, 0, 0};
      for (int i = 0; i < 7; i++) m_sh[i] = 8'h00;
      for (int i = 0; i < 6; i++) m_al[i] = 8'h00;
      m_clo = 0; m_chi = 0; m_run = 0; m_snap = 0; m_cen = 0;
      m_ie = 0; m_flag = 0; m_mq = 0; m_running = 0; m_cnt = TPS - 1;
    end else begin
      pulse = m_run && tick_i && (m_cnt == 0);
      match = 1;
      for (int i = 0; i < 6; i++) if (tobcd(m_t[i]) != m_al[i]) match = 0;
      if (reg_we_i && reg_addr_i == 5'd14 && reg_wdata_i[1] && !m_snap)
        for (int i = 0; i < 7; i++) m_sh[i] = tobcd(m_t[i]);
      if (!m_run) m_cnt = TPS - 1;
      else if (tick_i) begin
        if (m_cnt == 0) begin
          if (m_cen && m_t[0] == 0 && m_t[1] == 0) begin
            rl = TPS - 1 - int'($signed({m_chi, m_clo}));
            m_cnt = (rl < 0) ? 0 : rl;
          end else m_cnt = TPS - 1;
        end else m_cnt--;
      end
      m_running = m_run ? (m_running || tick_i) : 1'b0;
      setf = match && !m_mq && m_ie;
      clrf = reg_we_i && reg_addr_i == 5'd15 && reg_wdata_i[1];
      m_mq = match;
      if (setf) m_flag = 1; else if (clrf) m_flag = 0;
      if (pulse) advance();
      if (reg_we_i) begin
        if (reg_addr_i <= 5'd6) m_t[reg_addr_i] = frombcd(reg_wdata_i);
        else if (reg_addr_i >= 5'd8 && reg_addr_i <= 5'd13) m_al[reg_addr_i - 8] = reg_wdata_i;
        else if (reg_addr_i == 5'd14) begin
          m_run = reg_wdata_i[0]; m_snap = reg_wdata_i[1]; m_cen = reg_wdata_i[2];
        end
        else if (reg_addr_i == 5'd15) m_ie = reg_wdata_i[0];
        else if (reg_addr_i == 5'd16) m_clo = reg_wdata_i;
        else if (reg_addr_i == 5'd17) m_chi = reg_wdata_i;
      end
    end
  end

  function automatic logic [7:0] m_read(logic [4:0] a);
    if (a <= 5'd6) return m_sh[a];
    if (a >= 5'd8 && a <= 5'd13) return m_al[a - 8];
    if (a == 5'd14) return {5'b0, m_cen, m_snap, m_run};
    if (a == 5'd15) return {6'b0, m_flag, m_ie};
    if (a == 5'd16) return m_clo;
    if (a == 5'd17) return m_chi;
    if (a == 5'd18) return {7'b0, m_running};
    return 8'h00;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk_i) begin
    if (started && rst_ni) begin
      chk("R4", {7'b0, running_o}, {7'b0, m_running});
      chk("R10", {7'b0, alarm_irq_o}, {7'b0, m_flag});
      chk(cur_tag, reg_rdata_o, m_read(reg_addr_i));
    end
  end

  // tick enable: two of every three cycles
  always @(posedge clk_i) begin
    cyc++;
    #2 tick_i = (cyc % 3) != 0;
  end

  // watchdog
  always @(posedge clk_i) begin
    if (cyc > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic nxt();
    @(posedge clk_i); #2;
  endtask
  task automatic wr(logic [4:0] a, logic [7:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    nxt();
    reg_we_i = 1'b0;
  endtask
  task automatic rdchk(string tag, logic [4:0] a, logic [7:0] exp);
    reg_addr_i = a; #1;
    chk(tag, reg_rdata_o, exp);
    nxt();
  endtask
  task automatic snap();
    wr(5'd14, ctrl_v); wr(5'd14, ctrl_v | 8'h02);
  endtask
  task automatic set_time(logic [7:0] y, logic [7:0] mo, logic [7:0] d, logic [7:0] h,
                          logic [7:0] mi, logic [7:0] s, logic [7:0] w);
    wr(5'd0, s); wr(5'd1, mi); wr(5'd2, h); wr(5'd3, d); wr(5'd4, mo); wr(5'd5, y); wr(5'd6, w);
  endtask
  task automatic ctrl(logic [7:0] v);
    ctrl_v = v; wr(5'd14, v);
  endtask
  task automatic poll_sec(int n);
    for (int i = 0; i < n; i++) begin snap(); reg_addr_i = 5'd0; nxt(); end
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) nxt();
  endtask

  logic [7:0] held;

  initial begin
    idle(3);
    rst_ni = 1'b1;
    started = 1;
    nxt();
    // reset state
    chk("R4", {7'b0, running_o}, 8'h00);
    chk("R10", {7'b0, alarm_irq_o}, 8'h00);
    rdchk("R1", 5'd0, 8'h00);
    rdchk("R1", 5'd14, 8'h00);
    snap();
    rdchk("R1", 5'd3, 8'h01);
    rdchk("R1", 5'd4, 8'h01);

    // stopped counter holds
    cur_tag = "R3";
    set_time(8'h21, 8'h07, 8'h15, 8'h12, 8'h34, 8'h56, 8'h02);
    idle(60);
    snap();
    rdchk("R3", 5'd0, 8'h56);
    rdchk("R3", 5'd1, 8'h34);
    rdchk("R1", 5'd6, 8'h02);

    // plain seconds
    cur_tag = "R5";
    ctrl(8'h01);
    poll_sec(30);
    chk("R4", {7'b0, running_o}, 8'h01);
    rdchk("R4", 5'd18, 8'h01);

    // snapshot only on rising edge
    cur_tag = "R2";
    snap();
    reg_addr_i = 5'd0; #1; held = reg_rdata_o;
    idle(30);
    wr(5'd14, ctrl_v | 8'h02);
    rdchk("R2", 5'd0, held);
    ctrl(8'h00);
    idle(2);
    chk("R4", {7'b0, running_o}, 8'h00);

    // leap February
    cur_tag = "R7";
    set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h58, 8'h03);
    ctrl(8'h01);
    for (int i = 0; i < 2000 && m_t[3] != 29; i++) nxt();
    ctrl(8'h00);
    snap();
    rdchk("R7", 5'd3, 8'h29); rdchk("R7", 5'd4, 8'h02); rdchk("R7", 5'd6, 8'h04);
    rdchk("R6", 5'd2, 8'h00); rdchk("R6", 5'd1, 8'h00); rdchk("R6", 5'd0, 8'h00);

    // non-leap February
    set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 8'h02);
    ctrl(8'h01);
    for (int i = 0; i < 2000 && m_t[4] != 3; i++) nxt();
    ctrl(8'h00);
    snap();
    rdchk("R7", 5'd3, 8'h01); rdchk("R7", 5'd4, 8'h03); rdchk("R7", 5'd6, 8'h03);

    // end of century
    cur_tag = "R8";
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59, 8'h06);
    ctrl(8'h01);
    for (int i = 0; i < 2000 && m_t[5] != 0; i++) nxt();
    ctrl(8'h00);
    snap();
    rdchk("R8", 5'd5, 8'h00); rdchk("R8", 5'd4, 8'h01); rdchk("R8", 5'd3, 8'h01);
    rdchk("R7", 5'd6, 8'h00); rdchk("R6", 5'd2, 8'h00);

    // hourly correction: positive, negative, floored, disabled
    cur_tag = "R9";
    wr(5'd16, 8'h03); wr(5'd17, 8'h00);
    set_time(8'h24, 8'h03, 8'h10, 8'h05, 8'h59, 8'h57, 8'h00);
    ctrl(8'h05); poll_sec(60); ctrl(8'h00);
    wr(5'd16, 8'hFC); wr(5'd17, 8'hFF);
    set_time(8'h24, 8'h03, 8'h10, 8'h06, 8'h59, 8'h57, 8'h00);
    ctrl(8'h05); poll_sec(60); ctrl(8'h00);
    wr(5'd16, 8'h64); wr(5'd17, 8'h00);
    set_time(8'h24, 8'h03, 8'h10, 8'h07, 8'h59, 8'h58, 8'h00);
    ctrl(8'h05); poll_sec(40); ctrl(8'h00);
    set_time(8'h24, 8'h03, 8'h10, 8'h08, 8'h59, 8'h58, 8'h00);
    ctrl(8'h01); poll_sec(40); ctrl(8'h00);
    rdchk("R9", 5'd16, 8'h64);

    // alarm
    cur_tag = "R10";
    set_time(8'h24, 8'h06, 8'h05, 8'h10, 8'h20, 8'h30, 8'h03);
    wr(5'd8, 8'h32); wr(5'd9, 8'h20); wr(5'd10, 8'h10);
    wr(5'd11, 8'h05); wr(5'd12, 8'h06); wr(5'd13, 8'h24);
    wr(5'd15, 8'h01);
    ctrl(8'h01);
    for (int i = 0; i < 2000 && !m_flag; i++) nxt();
    nxt();
    chk("R10", {7'b0, alarm_irq_o}, 8'h01);
    rdchk("R10", 5'd15, 8'h03);
    cur_tag = "R11";
    idle(5);
    chk("R11", {7'b0, alarm_irq_o}, 8'h01);
    wr(5'd15, 8'h03);
    chk("R11", {7'b0, alarm_irq_o}, 8'h00);
    idle(5);
    chk("R11", {7'b0, alarm_irq_o}, 8'h00);

    // alarm disabled
    cur_tag = "R12";
    wr(5'd15, 8'h00);
    wr(5'd8, 8'h36);
    for (int i = 0; i < 2000 && m_t[0] != 37; i++) nxt();
    chk("R12", {7'b0, alarm_irq_o}, 8'h00);
    rdchk("R12", 5'd15, 8'h00);
    ctrl(8'h00);
    idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule